// File: doc/BRIEF.md
# I2C Register-Access Target Engine

This block is the serial front end of a small peripheral that holds four byte-wide registers. It samples the two I2C lines with the system clock and runs each line through a synchronizer and a majority-free agreement filter. It then tracks bus framing and answers only to the fixed 7-bit target address 0x41. Register storage lives outside. The engine presents a 2-bit register index. It issues a one-cycle write strobe with the received byte, and a one-cycle read strobe in the cycle where it captures the byte that the storage shows on `rd_data`.

A write transaction carries a pointer byte first, and only its two low bits are kept. Any further bytes in that write all land on the selected register. The pointer persists across STOP and START boundaries, so a later read, with or without a repeated START, returns bytes from the register chosen last. Reads last as long as the controller keeps acknowledging. A NACK makes the engine let go of SDA and wait for the next START or STOP.

The open-drain output is modelled as `sda_drive_low`: when it is 1 the pad pulls SDA low, and when it is 0 SDA is released. The engine changes it only after a filtered falling SCL edge.

Top module: `i2c_regtarget`

## Requirements
- R1: An address byte whose upper seven bits equal 1000001 (0x41) is acknowledged. Bit 0 of that byte selects the direction: 1 is read, 0 is write. A mismatching address is not acknowledged, and every later byte up to the next START or STOP is ignored, with no strobe, no pointer change and SDA released.
- R2: A falling SDA edge while SCL is high is a START (or repeated START) and begins a new address byte. A rising SDA edge while SCL is high is a STOP, after which nothing is acknowledged until a new START.
- R3: The target acknowledges by holding SDA low through the high phase of the ninth clock after a matching address byte and after every byte it receives in a write.
- R4: The first byte after a write address sets `reg_sel` to its bits [1:0]. Bits [7:2] are ignored. Encoding: 0 input, 1 output, 2 polarity inversion, 3 configuration.
- R5: `reg_sel` keeps its value across transactions until a new pointer byte arrives. A read without a preceding pointer byte returns the register selected last.
- R6: Every data byte after the pointer byte in a write gives exactly one `wr_stb` pulse, with that byte on `wr_data` and `reg_sel` unchanged. `wr_stb` and `rd_stb` never coincide.
- R7: In a read, every byte sent is taken from `rd_data` with one `rd_stb` pulse and shifted out MSB first. Reading goes on for as long as the controller acknowledges.
- R8: When the controller answers a read byte with NACK, the target releases SDA and drives nothing more until the next START or STOP.
- R9: A repeated START followed by a read address keeps the pointer chosen before the restart.
- R10: A pulse on SCL or SDA shorter than FILT_LEN system clocks (after synchronization) is ignored. A level held for longer is accepted.
- R11: `sda_drive_low` changes only while SCL is low. It never changes between two consecutive high samples of SCL.
- R12: During and right after reset, `reg_sel` is 0, SDA is released, both strobes are low, and the engine waits for a START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_sel | output | 2 | Selected register index |
| wr_stb | output | 1 | One-cycle pulse: write `wr_data` to register `reg_sel` |
| wr_data | output | 8 | Byte received for the selected register |
| rd_stb | output | 1 | One-cycle pulse: `rd_data` is captured in this cycle |
| rd_data | input | 8 | Current value of register `reg_sel` |

## Verification
Most faults in this engine become visible on SDA within one byte. A wrong bit count or a wrong state makes the acknowledge slot move or vanish, so the controller sees NACK at the ninth clock of the byte concerned. A stale or corrupted pointer shows up at the first read that follows, as the wrong byte value, even across a STOP. Loss of sync after a NACK or a filtered glitch shows up as a stray acknowledge on a byte clocked without a START. A drive change timed to the wrong edge shows up as a change of SDA while SCL is high, which a controller would decode as a START or STOP.

// File: rtl/i2c_regtarget.sv
module i2c_regtarget #(
  parameter logic [6:0] DEV_ADDR = 7'h41,
  parameter int         FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low,
  output logic [1:0] reg_sel,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       rd_stb,
  input  logic [7:0] rd_data
);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_RDATA} state_t;

  localparam logic [3:0] ACK_FALL = 4'd8;
  localparam logic [3:0] ACK_HIGH = 4'd9;

  logic [1:0]          scl_sync, sda_sync;
  logic [FILT_LEN-1:0] scl_hist, sda_hist;
  logic                scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_hist <= '1;
      sda_hist <= '1;
      scl_f    <= 1'b1;
      sda_f    <= 1'b1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_hist <= {scl_hist[FILT_LEN-2:0], scl_sync[1]};
      sda_hist <= {sda_hist[FILT_LEN-2:0], sda_sync[1]};
      if (&scl_hist) scl_f <= 1'b1; else if (~|scl_hist) scl_f <= 1'b0;
      if (&sda_hist) sda_f <= 1'b1; else if (~|sda_hist) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  state_t     state;
  logic [3:0] bit_cnt;
  logic [7:0] sh;
  logic [6:0] tx;
  logic       rw, mnack;
  logic       in_idle;

  assign in_idle = (state == ST_IDLE);
  assign rd_stb  = scl_fall && !start_c && !stop_c && (bit_cnt == ACK_HIGH) &&
                   (((state == ST_ADDR) && rw) || ((state == ST_RDATA) && !mnack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      bit_cnt       <= '0;
      sh            <= '0;
      tx            <= '0;
      rw            <= 1'b0;
      mnack         <= 1'b0;
      reg_sel       <= '0;
      wr_stb        <= 1'b0;
      wr_data       <= '0;
      sda_drive_low <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        state         <= ST_ADDR;
        bit_cnt       <= '0;
        sda_drive_low <= 1'b0;
      end else if (stop_c) begin
        state         <= ST_IDLE;
        bit_cnt       <= '0;
        sda_drive_low <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < ACK_FALL) sh <= {sh[6:0], sda_f};
          if (bit_cnt == ACK_FALL) mnack <= sda_f;
          if (bit_cnt != ACK_HIGH) bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall) begin
          if (bit_cnt == ACK_FALL) begin
            case (state)
              ST_ADDR:
                if (sh[7:1] == DEV_ADDR) begin
                  rw            <= sh[0];
                  sda_drive_low <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              ST_CMD: begin
                reg_sel       <= sh[1:0];
                sda_drive_low <= 1'b1;
              end
              ST_WDATA: begin
                wr_stb        <= 1'b1;
                wr_data       <= sh;
                sda_drive_low <= 1'b1;
              end
              default: sda_drive_low <= 1'b0;
            endcase
          end else if (bit_cnt == ACK_HIGH) begin
            bit_cnt       <= '0;
            sda_drive_low <= 1'b0;
            case (state)
              ST_ADDR:  state <= rw ? ST_RDATA : ST_CMD;
              ST_CMD:   state <= ST_WDATA;
              ST_RDATA: if (mnack) state <= ST_IDLE;
              default:  state <= state;
            endcase
            if (rd_stb) begin
              tx            <= rd_data[6:0];
              sda_drive_low <= ~rd_data[7];
            end
          end else if (state == ST_RDATA && bit_cnt != 4'd0) begin
            tx            <= {tx[5:0], 1'b0};
            sda_drive_low <= ~tx[6];
          end
        end
      end
    end
  end

endmodule

module i2c_regtarget_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_drive_low,
  input logic [1:0] reg_sel,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       in_idle,
  input logic       scl_fall
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_drive_low); // R8

  AST_DRIVE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_drive_low)); // R11

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb)); // R6

  AST_RDSTB_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !scl_i); // R7

  AST_SEL_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_sel) |-> $past(scl_fall)); // R4

endmodule

bind i2c_regtarget i2c_regtarget_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_drive_low(sda_drive_low),
  .reg_sel(reg_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .in_idle(in_idle), .scl_fall(scl_fall)
);

// File: tb/i2c_regtarget_tb.sv
module i2c_regtarget_tb;

  localparam int H = 20;
  localparam logic [15:0] VEC [6] = '{16'h01A5, 16'h023C, 16'h030F,
                                      16'h0081, 16'hFE5A, 16'h7DC3};

  logic       clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       drv;
  logic       sda_line;
  logic [1:0] sel;
  logic       wstb, rstb;
  logic [7:0] wdat, rdat;
  logic [7:0] regs [4];
  int nchk = 0, nfail = 0, wr_cnt = 0, rd_cnt = 0, r11_viol = 0;
  logic scl_p, drv_p;

  assign sda_line = sda_m & ~drv;
  assign rdat     = regs[sel];

  i2c_regtarget u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low(drv), .reg_sel(sel), .wr_stb(wstb), .wr_data(wdat),
    .rd_stb(rstb), .rd_data(rdat)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      regs[0] <= 8'h11; regs[1] <= 8'h22; regs[2] <= 8'h33; regs[3] <= 8'h44;
    end else begin
      if (wstb) begin regs[sel] <= wdat; wr_cnt++; end
      if (rstb) rd_cnt++;
    end
    scl_p <= scl_m;
    drv_p <= drv;
    if (rst_n && scl_m && scl_p && (drv !== drv_p)) r11_viol++;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H/2);
    ack = (sda_line == 1'b0);
    tick(H/2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic rbyte(input logic ack_send, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_m = 1'b1; tick(H/2);
      b[i] = sda_line;
      tick(H/2);
      scl_m = 1'b0; tick(2);
    end
    sda_m = ack_send ? 1'b0 : 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] b;
    int         w0, r0;

    tick(4);
    chk("R12 drive during reset", drv, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R12 sda released", drv, 0);
    chk("R12 reg_sel", sel, 0);
    chk("R12 wr_stb", wstb, 0);
    chk("R12 rd_stb", rstb, 0);

    // R5 / R12: read with no pointer byte returns register 0
    bus_start(); wbyte(8'h83, a); chk("R1 read address ack", a, 1);
    rbyte(1'b0, b); chk("R5 read after reset", b, 8'h11);
    bus_stop();

    for (int k = 0; k < 6; k++) begin
      w0 = wr_cnt;
      bus_start();
      wbyte(8'h82, a);          chk("R1 write address ack", a, 1);
      wbyte(VEC[k][15:8], a);   chk("R3 pointer ack", a, 1);
      wbyte(VEC[k][7:0], a);    chk("R3 data ack", a, 1);
      bus_stop();
      chk("R4 reg_sel from pointer", sel, {30'd0, VEC[k][9:8]});
      chk("R6 wr_data", wdat, VEC[k][7:0]);
      chk("R6 one strobe", wr_cnt - w0, 1);
      bus_start();
      wbyte(8'h83, a);          chk("R1 read address ack", a, 1);
      rbyte(1'b0, b);           chk("R7 read value", b, VEC[k][7:0]);
      bus_stop();
    end

    // R6: multi-byte write to one register
    w0 = wr_cnt;
    bus_start(); wbyte(8'h82, a); wbyte(8'h03, a);
    wbyte(8'h10, a); chk("R3 burst ack 1", a, 1);
    wbyte(8'h20, a); chk("R3 burst ack 2", a, 1);
    wbyte(8'h30, a); chk("R3 burst ack 3", a, 1);
    bus_stop();
    chk("R6 burst strobes", wr_cnt - w0, 3);
    chk("R6 burst last data", wdat, 8'h30);
    chk("R6 burst reg_sel", sel, 3);

    // R7 / R5: multi-byte read without pointer byte
    r0 = rd_cnt;
    bus_start(); wbyte(8'h83, a);
    rbyte(1'b1, b); chk("R5 burst read 1", b, 8'h30);
    rbyte(1'b1, b); chk("R7 burst read 2", b, 8'h30);
    rbyte(1'b0, b); chk("R7 burst read 3", b, 8'h30);
    bus_stop();
    chk("R7 read strobes", rd_cnt - r0, 3);

    // R9: repeated START keeps the pointer; R8: release after NACK
    bus_start(); wbyte(8'h82, a); wbyte(8'h01, a);
    bus_start(); wbyte(8'h83, a); chk("R9 restart address ack", a, 1);
    rbyte(1'b0, b); chk("R9 restart read", b, 8'hC3);
    rbyte(1'b0, b); chk("R8 nothing driven after NACK", b, 8'hFF);
    chk("R8 sda released", drv, 0);
    bus_stop();

    // R1: address mismatch ignored
    w0 = wr_cnt;
    bus_start();
    wbyte(8'h84, a); chk("R1 mismatch no ack", a, 0);
    wbyte(8'h02, a); chk("R1 ignored byte no ack", a, 0);
    wbyte(8'h55, a); chk("R1 ignored data no ack", a, 0);
    bus_stop();
    chk("R1 no write after mismatch", wr_cnt - w0, 0);
    chk("R1 pointer kept", sel, 1);

    // R2: after STOP, a byte without START is not acknowledged
    bus_start(); wbyte(8'h82, a); chk("R2 addressed", a, 1);
    bus_stop();
    scl_m = 1'b0; tick(H);
    wbyte(8'h82, a); chk("R2 no ack after stop", a, 0);
    bus_stop();

    // R10: short SDA pulse while SCL high is not a START
    sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(H);
    wbyte(8'h82, a); chk("R10 glitch ignored", a, 0);
    bus_stop();
    // R10: a long enough pulse is a START
    sda_m = 1'b0; tick(8);
    scl_m = 1'b0; tick(2);
    wbyte(8'h82, a); chk("R10 long pulse accepted", a, 1);
    bus_stop();

    chk("R11 drive changes only with SCL low", r11_viol, 0);
    summary();
    $finish;
  end

endmodule